// File: doc/BRIEF.md
# APB Down-Counting Interval Timer

This block is a single down-counting timer behind an APB slave port. Software programs a reload value, then turns the timer on. From that point the counter steps down by one on every clock where the tick-enable input is high. When a step is taken while the count is already zero, the timer raises an interrupt flag and reloads. In periodic mode the reload value is the programmed one. In free-running mode the counter reloads to all ones, so that inverting the count gives an increasing timestamp.

The pending flag is cleared by reading one of two acknowledge addresses, one belonging to the timer and one at block level. A mask bit gates the flag onto the interrupt pin and the masked status registers. The unmasked view stays readable at all times. A fixed identification word sits at the top of the map, and every transfer completes with no wait states.

Top module: `apb_down_timer`

## Requirements
- R1: After reset the control register reads 0, the current count reads 0, the raw flag at 0xA8 reads 0 and `irq_o` is low.
- R2: The reload register is written and read at offset 0x00. The control register sits at 0x08 and reads back its bits [2:0]: bit 0 enables the timer, bit 1 selects periodic mode (1) or free-running mode (0), and bit 2 masks the interrupt (1 = masked). The current count is read at 0x04.
- R3: A control write that sets bit 0 while the timer is disabled copies the reload value into the counter on that same clock edge.
- R4: A disabled timer holds its count. Writing the reload register while the timer is enabled leaves the current count unchanged.
- R5: When the timer is enabled, the count falls by exactly one on each clock edge where `tick_en` is high, and it holds while `tick_en` is low.
- R6: In periodic mode, a tick taken at count 0 reloads the counter from the reload register as it stands at that moment. A reload value N therefore gives an event every N+1 ticks.
- R7: In free-running mode, a tick taken at count 0 reloads the counter to all ones (0xFFFFFFFF).
- R8: A tick taken at count 0 while the timer is enabled sets the raw flag, which reads as bit 0 of 0xA8, whether or not the interrupt is masked.
- R9: `irq_o`, bit 0 of 0x10 and bit 0 of 0xA0 all equal the raw flag AND NOT the mask.
- R10: A completed read of 0x0C or of 0xA4 clears the raw flag. If a new event falls on the same edge as the clearing read, the flag stays set.
- R11: A read of 0xAC returns the VERSION parameter (default 0x3130322A). The acknowledge addresses and every unmapped address read as 0.
- R12: `pready` is always high and `pslverr` is always low, so every access completes in its first access-phase cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock, also the counting clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Error response, always low |
| tick_en | input | 1 | Count-step qualifier |
| irq_o | output | 1 | Masked timer interrupt |

## Verification
The hardest case to reach is an event that lands on the same edge as a clearing read. From the ports this means a tick at count zero has to coincide exactly with the edge that ends the acknowledge read. The stimulus gets there by loading a reload value of zero in periodic mode, so that every tick is an event. It then holds `tick_en` high through the acknowledge read and drops it right after that read's final edge, and the flag must still read as set. All other count checks pulse `tick_en` for an exact number of edges while no bus transfer is in flight, so every expected count follows directly from the pulse length.

// File: rtl/dtmr_pkg.sv
// Package: shared constants and types for the APB down-counting timer.
// Assumes byte addressing with 8-bit offsets and a 32-bit data bus.
package dtmr_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // Per-timer register offsets
    localparam logic [ADDR_W-1:0] OFF_RELOAD = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_ACK    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h10;
    // Block-level register offsets
    localparam logic [ADDR_W-1:0] OFF_GSTAT  = 8'hA0;
    localparam logic [ADDR_W-1:0] OFF_GACK   = 8'hA4;
    localparam logic [ADDR_W-1:0] OFF_RAW    = 8'hA8;
    localparam logic [ADDR_W-1:0] OFF_ID     = 8'hAC;

    // Control fields; bit order is software-visible
    typedef struct packed {
        logic mask;      // bit 2: 1 = interrupt masked
        logic periodic;  // bit 1: 1 = reload from register, 0 = reload all ones
        logic run;       // bit 0: timer enable
    } ctrl_t;

endpackage

// File: rtl/dtmr_bus_decode.sv
// Module: dtmr_bus_decode
// Turns APB control signals into single-cycle strobes for the timer registers.
// Assumes zero-wait-state transfers: an access completes in its first
// access-phase cycle (psel & penable).
module dtmr_bus_decode
    import dtmr_pkg::*;
(
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic              wr_reload,
    output logic              wr_ctrl,
    output logic              ack_read
);

    logic access;

    // Strobe generation for completed accesses
    always_comb begin
        access    = psel && penable;
        wr_reload = access && pwrite && (paddr == OFF_RELOAD);
        wr_ctrl   = access && pwrite && (paddr == OFF_CTRL);
        ack_read  = access && !pwrite && ((paddr == OFF_ACK) || (paddr == OFF_GACK));
    end

endmodule

// File: rtl/dtmr_counter.sv
// Module: dtmr_counter
// Down counter with load-on-start, periodic or all-ones reload, and an
// event pulse on each tick taken at zero. Assumes start only arrives
// while disabled.
module dtmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             periodic,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_evt
);

    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    logic at_zero;

    // Event decode: a tick taken at zero while running
    always_comb begin
        at_zero  = (cnt_o == '0);
        zero_evt = run && tick && !start && at_zero;
    end

    // Count register: start load, reload at zero, else decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (start) begin
            cnt_o <= reload_val;
        end else if (run && tick) begin
            if (at_zero) begin
                cnt_o <= periodic ? reload_val : ALL_ONES;
            end else begin
                cnt_o <= cnt_o - 1'b1;
            end
        end
    end

    // R3: start copies the reload value
    a_r3_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_o == $past(reload_val)));

    // R4: disabled counter holds
    a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(cnt_o));

    // R5: one step per tick
    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !start && !at_zero) |=> (cnt_o == $past(cnt_o) - 1'b1));

    // R6: periodic reload
    a_r6_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && periodic) |=> (cnt_o == $past(reload_val)));

    // R7: free-running reload
    a_r7_free_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && !periodic) |=> (cnt_o == ALL_ONES));

endmodule

// File: rtl/dtmr_irq.sv
// Module: dtmr_irq
// Holds the raw interrupt flag (set by events, cleared by acknowledge reads,
// set wins) and gates it with the mask.
module dtmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    input  logic mask,
    output logic raw_o,
    output logic irq_o
);

    // Raw flag: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_o <= 1'b0;
        end else if (set_evt) begin
            raw_o <= 1'b1;
        end else if (clr_req) begin
            raw_o <= 1'b0;
        end
    end

    // Masked output
    always_comb irq_o = raw_o && !mask;

    // R8: event sets the flag regardless of mask
    a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> raw_o);

    // R10: acknowledge clears when no event competes
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_evt) |=> !raw_o);

    // R10: flag never drops without an acknowledge
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_o && !clr_req) |=> raw_o);

endmodule

// File: rtl/apb_down_timer.sv
// Module: apb_down_timer (top)
// APB slave wrapping one down-counting timer: reload and control registers,
// read mux, clear-on-read acknowledge and masked interrupt output.
// Assumes a single clock for bus and counting, and zero wait states.
module apb_down_timer
    import dtmr_pkg::*;
#(
    parameter int          CNT_W   = 32,
    parameter logic [31:0] VERSION = 32'h3130_322A
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              tick_en,
    output logic              irq_o
);

    localparam int PAD_W = DATA_W - CNT_W;

    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  reload_q;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] count_rd;
    logic [DATA_W-1:0] reload_rd;
    logic              wr_reload;
    logic              wr_ctrl;
    logic              ack_read;
    logic              start;
    logic              zero_evt;
    logic              raw_flag;
    logic              unused_wdata;

    assign pready       = 1'b1;
    assign pslverr      = 1'b0;
    assign unused_wdata = ^pwdata;

    dtmr_bus_decode u_decode (
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .wr_reload (wr_reload),
        .wr_ctrl   (wr_ctrl),
        .ack_read  (ack_read)
    );

    // Start pulse: enable written while timer is off
    always_comb start = wr_ctrl && pwdata[0] && !ctrl_q.run;

    // Reload register
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            reload_q <= '0;
        end else if (wr_reload) begin
            reload_q <= pwdata[CNT_W-1:0];
        end
    end

    // Control register
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(pwdata[2:0]);
        end
    end

    dtmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (pclk),
        .rst_n      (presetn),
        .run        (ctrl_q.run),
        .periodic   (ctrl_q.periodic),
        .tick       (tick_en),
        .start      (start),
        .reload_val (reload_q),
        .cnt_o      (count),
        .zero_evt   (zero_evt)
    );

    dtmr_irq u_irq (
        .clk     (pclk),
        .rst_n   (presetn),
        .set_evt (zero_evt),
        .clr_req (ack_read),
        .mask    (ctrl_q.mask),
        .raw_o   (raw_flag),
        .irq_o   (irq_o)
    );

    // Width adaptation of counter-sized values onto the data bus
    generate
        if (PAD_W > 0) begin : g_pad
            assign count_rd  = {{PAD_W{1'b0}}, count};
            assign reload_rd = {{PAD_W{1'b0}}, reload_q};
        end else begin : g_nopad
            assign count_rd  = count;
            assign reload_rd = reload_q;
        end
    endgenerate

    // Read data mux; acknowledge and unmapped addresses return zero
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (paddr)
                OFF_RELOAD: prdata = reload_rd;
                OFF_COUNT:  prdata = count_rd;
                OFF_CTRL:   prdata = {{(DATA_W-3){1'b0}}, ctrl_q};
                OFF_STAT:   prdata = {{(DATA_W-1){1'b0}}, irq_o};
                OFF_GSTAT:  prdata = {{(DATA_W-1){1'b0}}, irq_o};
                OFF_RAW:    prdata = {{(DATA_W-1){1'b0}}, raw_flag};
                OFF_ID:     prdata = VERSION;
                default:    prdata = '0;
            endcase
        end
    end

    // R9: a masked timer never drives the pin
    a_r9_mask_blocks: assert property (@(posedge pclk) disable iff (!presetn)
        ctrl_q.mask |-> !irq_o);

    // R9: unmasked pin follows the raw flag
    a_r9_pin_tracks_raw: assert property (@(posedge pclk) disable iff (!presetn)
        !ctrl_q.mask |-> (irq_o == raw_flag));

    // R3: a start can only occur from the disabled state, then the timer runs
    a_r3_start_enables: assert property (@(posedge pclk) disable iff (!presetn)
        start |=> ctrl_q.run);

endmodule

// File: tb/tb_apb_down_timer.sv
// Scoreboard bench: read tasks queue expected values; a monitor pops and
// compares them against prdata in each read access phase.
module tb_apb_down_timer;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic        tick_en = 1'b0;
    logic        irq_o;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) pclk = ~pclk;

    apb_down_timer dut (
        .pclk    (pclk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pready  (pready),
        .pslverr (pslverr),
        .tick_en (tick_en),
        .irq_o   (irq_o)
    );

    // Monitor: compare read data against the queued expectation
    always @(negedge pclk) begin
        if (psel && penable && !pwrite) begin
            checks++;
            if (pready !== 1'b1 || pslverr !== 1'b0) begin
                errors++;
                $display("FAIL R12 pready=%b pslverr=%b expected 1/0", pready, pslverr);
            end
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard read with no expectation at %h", paddr);
            end else begin
                exp_t item;
                item = exp_q.pop_front();
                checks++;
                if (prdata !== item.exp) begin
                    errors++;
                    $display("FAIL %s addr=%h actual=%h expected=%h",
                             item.tag, paddr, prdata, item.exp);
                end
            end
        end
    end

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge pclk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(posedge pclk); #1;
        penable = 1'b1;
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_t item;
        item.exp = e;
        item.tag = tag;
        exp_q.push_back(item);
        @(posedge pclk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(posedge pclk); #1;
        penable = 1'b1;
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    // Exactly n clock edges with tick_en high
    task automatic ticks(input int n);
        @(posedge pclk); #1;
        tick_en = 1'b1;
        repeat (n) @(posedge pclk);
        #1;
        tick_en = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        @(negedge pclk);
        checks++;
        if (irq_o !== e) begin
            errors++;
            $display("FAIL %s irq_o actual=%b expected=%b", tag, irq_o, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge pclk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge pclk);
        #1 presetn = 1'b1;

        // R1: reset state
        check_irq(1'b0, "R1");
        apb_read(8'h08, 32'h0, "R1 ctrl");
        apb_read(8'h04, 32'h0, "R1 count");
        apb_read(8'hA8, 32'h0, "R1 raw");

        // R2: reload read-back; R3: start loads counter
        apb_write(8'h00, 32'd5);
        apb_read(8'h00, 32'd5, "R2 reload");
        apb_write(8'h08, 32'h3);
        apb_read(8'h08, 32'h3, "R2 ctrl");
        apb_read(8'h04, 32'd5, "R3 start load");

        // R5: exact stepping and holding with tick_en low
        ticks(3);
        apb_read(8'h04, 32'd2, "R5 step");
        repeat (4) @(posedge pclk);
        apb_read(8'h04, 32'd2, "R5 hold");
        ticks(2);
        apb_read(8'hA8, 32'h0, "R8 no event yet");

        // R6/R8/R9: zero tick reloads and raises irq
        ticks(1);
        apb_read(8'h04, 32'd5, "R6 periodic reload");
        apb_read(8'hA8, 32'h1, "R8 raw set");
        apb_read(8'h10, 32'h1, "R9 status");
        apb_read(8'hA0, 32'h1, "R9 block status");
        check_irq(1'b1, "R9");

        // R10/R11: acknowledge read returns zero and clears
        apb_read(8'h0C, 32'h0, "R11 ack reads zero");
        apb_read(8'hA8, 32'h0, "R10 ack clears");
        check_irq(1'b0, "R10");

        // Masked event: R8 raw still set, R9 outputs stay low
        apb_write(8'h08, 32'h7);
        ticks(6);
        apb_read(8'h04, 32'd5, "R6 second period");
        apb_read(8'hA8, 32'h1, "R8 raw under mask");
        apb_read(8'h10, 32'h0, "R9 masked status");
        check_irq(1'b0, "R9 masked");
        apb_read(8'hA4, 32'h0, "R10 block ack");
        apb_read(8'hA8, 32'h0, "R10 block ack clears");

        // R4: reload write while running leaves count; R6 uses new value
        apb_write(8'h00, 32'd9);
        apb_read(8'h04, 32'd5, "R4 reload write no effect");
        ticks(6);
        apb_read(8'h04, 32'd9, "R6 new reload value");

        // R4: disabled timer holds
        apb_write(8'h08, 32'h4);
        ticks(3);
        apb_read(8'h04, 32'd9, "R4 hold when off");

        // R7: free-running reload to all ones
        apb_read(8'h0C, 32'h0, "R10 ack");
        apb_write(8'h08, 32'h5);
        apb_read(8'h04, 32'd9, "R3 restart load");
        ticks(10);
        apb_read(8'h04, 32'hFFFF_FFFF, "R7 all ones");
        apb_read(8'hA8, 32'h1, "R8 raw free mode");
        ticks(1);
        apb_read(8'h04, 32'hFFFF_FFFE, "R7 continues down");

        // R10: event on the same edge as the acknowledge keeps the flag
        apb_write(8'h08, 32'h4);
        apb_write(8'h00, 32'd0);
        apb_write(8'h08, 32'h3);
        @(posedge pclk); #1;
        tick_en = 1'b1;
        apb_read(8'h0C, 32'h0, "R10 ack during event");
        tick_en = 1'b0;
        apb_read(8'hA8, 32'h1, "R10 set wins");
        check_irq(1'b1, "R10 set wins");
        apb_read(8'h0C, 32'h0, "R10 ack");
        apb_read(8'hA8, 32'h0, "R10 cleared");

        // R11: identification and unmapped addresses
        apb_read(8'hAC, 32'h3130_322A, "R11 version");
        apb_read(8'h14, 32'h0, "R11 unmapped");
        apb_read(8'hB0, 32'h0, "R11 unmapped high");

        repeat (2) @(posedge pclk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard has %0d unconsumed items", exp_q.size());
        end
        finish_run();
    end

endmodule